// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block turns bytes into an asynchronous serial stream. Software or an upstream engine writes bytes into a small internal queue. A serializer takes them out one at a time and sends each as a frame. A frame is a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Between frames the line rests high. Timing comes from an external baud tick pulse. Each bit lasts either 16 or 8 of these ticks.

A new frame starts only at a character boundary, and only when all of these hold:
- both enables are set;
- no abort is pending;
- if clear-to-send gating is on, the synchronized clear-to-send input is asserted.

Dropping an enable or clear-to-send during a frame never cuts the frame short.

A smart-card mode fixes the bit at 16 ticks and the stop count at two. During the first stop bit it watches the sensed line. If a receiver pulls the line low there, it is signalling a parity error. The block then latches an abort that blocks all further frames until the abort is cleared. The transmit interrupt output has two modes. In one it reports the queue fill level against a threshold. In the other it reports that everything, including the last stop bit, has left the serializer.

Top module: `uart_tx_fc`

## Requirements
- R1: The line `txd` is high out of reset and whenever the block is not busy. A frame is one low start bit, then DATA_W data bits with the least significant bit first, then the optional parity bit, then high stop bits.
- R2: A frame starts only while `en_global` and `en_tx` are both 1. Clearing either one during a frame lets that frame complete. The frame after it does not start until both enables are set again.
- R3: When `cts_fc_en` is 1, a frame starts only while the synchronized `cts` input is 1. When `cts` is 0, queued bytes stay pending.
- R4: Outside smart-card mode, each bit lasts 16 baud ticks when `high_speed` is 0 and 8 baud ticks when it is 1.
- R5: When `par_en` is 1, one parity bit follows the data. With `par_odd` = 0, the parity bit makes the total number of ones in the data plus parity bit even. With `par_odd` = 1, it makes that total odd.
- R6: Outside smart-card mode, a frame ends with one stop bit when `two_stop` is 0 and with two stop bits when it is 1.
- R7: With `smart_mode` = 1, every bit lasts 16 ticks and every frame has two stop bits, whatever `high_speed` and `two_stop` are set to.
- R8: In smart-card mode, `line_in` is checked at the middle of the first stop bit. If it is low there, `abort_flag` sets and the current frame still completes. While `abort_flag` is set, no new frame starts. A one-cycle `abort_clr` pulse clears the flag.
- R9: With `eot_mode` = 0, `tx_irq` is 1 exactly when the queue fill level is at most `thresh`. With `eot_mode` = 1, `tx_irq` is 1 only when the queue is empty and no frame is in progress.
- R10: `wr_ready` is 0 while the queue holds FIFO_DEPTH bytes. A write attempted then is dropped. Accepted bytes are sent in the order they were written.
- R11: `busy` is 1 while a frame is in progress or the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at the oversampled bit rate |
| en_global | input | 1 | Global enable |
| en_tx | input | 1 | Transmit enable |
| cts_fc_en | input | 1 | Gate frame starts on clear-to-send |
| cts | input | 1 | Clear-to-send, asynchronous, active high |
| high_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| eot_mode | input | 1 | Interrupt mode select: serializer empty instead of threshold |
| smart_mode | input | 1 | Smart-card mode |
| two_stop | input | 1 | Two stop bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | DATA_W | Byte to queue |
| wr_ready | output | 1 | Queue has room |
| thresh | input | $clog2(FIFO_DEPTH)+1 | Fill level at or below which `tx_irq` sets in threshold mode |
| line_in | input | 1 | Sensed serial line, used for smart-card error detection |
| abort_clr | input | 1 | Clears the abort flag |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress or bytes pending |
| tx_irq | output | 1 | Transmit interrupt flag |
| abort_flag | output | 1 | Smart-card abort latched |
| fifo_level | output | $clog2(FIFO_DEPTH)+1 | Number of queued bytes |

## Verification
The hardest case to reach is the smart-card abort. It needs `line_in` low at one narrow point: the middle of the first stop bit of a frame that is already in flight. The bench feeds `line_in` from `txd` through an AND gate with an injected pull-down. It detects the start edge of a frame and counts ten and a quarter bit periods. It then holds the line low for half a bit, which brackets the design's midpoint sample. Next it shows that a byte queued afterwards stays unsent until the clear pulse. The stop-bit case uses a similar method. It sends frames back to back, so that a missing second stop bit shows up as a premature start bit at the expected second-stop sample point.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      TX_IDLE  = 3'd0,
      TX_START = 3'd1,
      TX_DATA  = 3'd2,
      TX_PAR   = 3'd3,
      TX_STOP  = 3'd4
   } tx_state_e;

   function automatic logic calc_parity(input logic [15:0] bits, input logic odd);
      return odd ? ~(^bits) : (^bits);
   endfunction

endpackage

// File: rtl/tx_sync.sv
module tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic          full,
   output logic [AW:0]   level
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   cnt;
   logic          do_wr, do_rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk)
      if (do_wr) mem[wptr] <= wr_data;

   assign rd_data = mem[rptr];
   assign level   = cnt;
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          baud_tick,
   input  logic [CW-1:0] tpb,
   output logic          bit_done,
   output logic          mid_hit
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] last, half;

   assign last = tpb - 1'b1;
   assign half = (tpb >> 1) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (restart)     cnt <= '0;
      else if (baud_tick)   cnt <= (cnt == last) ? '0 : cnt + 1'b1;
   end

   assign bit_done = baud_tick && !restart && (cnt == last);
   assign mid_hit  = baud_tick && !restart && (cnt == half);
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
   import uart_tx_pkg::*;
#(
   parameter int DW = 8,
   localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] start_data,
   input  logic          par_en,
   input  logic          par_odd,
   input  logic          nstop2,
   input  logic          smart,
   input  logic          line_in,
   input  logic          bit_done,
   input  logic          mid_hit,
   output logic          txd,
   output logic          active,
   output logic          nack_seen
);
   tx_state_e     state;
   logic [DW-1:0] shreg;
   logic [IW-1:0] idx;
   logic          par_q, par_en_q, two_q, smart_q, stop_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         txd       <= 1'b1;
         shreg     <= '0;
         idx       <= '0;
         par_q     <= 1'b0;
         par_en_q  <= 1'b0;
         two_q     <= 1'b0;
         smart_q   <= 1'b0;
         stop_idx  <= 1'b0;
         nack_seen <= 1'b0;
      end else begin
         nack_seen <= 1'b0;
         case (state)
            TX_IDLE: begin
               txd <= 1'b1;
               if (start) begin
                  state    <= TX_START;
                  txd      <= 1'b0;
                  shreg    <= start_data;
                  par_q    <= calc_parity(16'(start_data), par_odd);
                  par_en_q <= par_en;
                  two_q    <= nstop2;
                  smart_q  <= smart;
               end
            end
            TX_START: if (bit_done) begin
               state <= TX_DATA;
               txd   <= shreg[0];
               shreg <= shreg >> 1;
               idx   <= '0;
            end
            TX_DATA: if (bit_done) begin
               if (idx == IW'(DW-1)) begin
                  if (par_en_q) begin
                     state <= TX_PAR;
                     txd   <= par_q;
                  end else begin
                     state    <= TX_STOP;
                     txd      <= 1'b1;
                     stop_idx <= 1'b0;
                  end
               end else begin
                  idx   <= idx + 1'b1;
                  txd   <= shreg[0];
                  shreg <= shreg >> 1;
               end
            end
            TX_PAR: if (bit_done) begin
               state    <= TX_STOP;
               txd      <= 1'b1;
               stop_idx <= 1'b0;
            end
            TX_STOP: begin
               if (smart_q && !stop_idx && mid_hit && !line_in)
                  nack_seen <= 1'b1;
               if (bit_done) begin
                  if (stop_idx == two_q) state <= TX_IDLE;
                  else                   stop_idx <= 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign active = (state != TX_IDLE);
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 8,
   parameter int OVS_NORMAL  = 16,
   parameter int OVS_FAST    = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LW = $clog2(FIFO_DEPTH) + 1,
   localparam int CW = $clog2(OVS_NORMAL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              en_global,
   input  logic              en_tx,
   input  logic              cts_fc_en,
   input  logic              cts,
   input  logic              high_speed,
   input  logic              eot_mode,
   input  logic              smart_mode,
   input  logic              two_stop,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic [LW-1:0]     thresh,
   input  logic              line_in,
   input  logic              abort_clr,
   output logic              txd,
   output logic              busy,
   output logic              tx_irq,
   output logic              abort_flag,
   output logic [LW-1:0]     fifo_level
);
   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two and at least 2");
      end
      if (OVS_FAST < 2 || OVS_FAST >= OVS_NORMAL || (OVS_FAST % 2) != 0) begin : g_bad_ovs
         $error("OVS_FAST must be even and below OVS_NORMAL");
      end
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_dw
         $error("DATA_W must be between 5 and 16");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              cts_s;
   logic              fifo_empty, fifo_full;
   logic [DATA_W-1:0] head;
   logic              ser_active, nack_seen;
   logic              bit_done, mid_hit;
   logic              start_go;
   logic              abort_q;
   logic [CW-1:0]     tpb;

   tx_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_s)
   );

   assign start_go = !ser_active && !fifo_empty && en_global && en_tx &&
                     !abort_q && (!cts_fc_en || cts_s);

   tx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_valid), .wr_data(wr_data),
      .rd_en(start_go), .rd_data(head),
      .empty(fifo_empty), .full(fifo_full), .level(fifo_level)
   );

   assign tpb = (high_speed && !smart_mode) ? CW'(OVS_FAST) : CW'(OVS_NORMAL);

   tx_bit_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(start_go), .baud_tick(baud_tick),
      .tpb(tpb), .bit_done(bit_done), .mid_hit(mid_hit)
   );

   tx_serializer #(.DW(DATA_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .start(start_go), .start_data(head),
      .par_en(par_en), .par_odd(par_odd), .nstop2(two_stop || smart_mode),
      .smart(smart_mode), .line_in(line_in),
      .bit_done(bit_done), .mid_hit(mid_hit),
      .txd(txd), .active(ser_active), .nack_seen(nack_seen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          abort_q <= 1'b0;
      else if (nack_seen)  abort_q <= 1'b1;
      else if (abort_clr)  abort_q <= 1'b0;
   end

   assign abort_flag = abort_q;
   assign wr_ready   = !fifo_full;
   assign busy       = ser_active || !fifo_empty;
   assign tx_irq     = eot_mode ? (fifo_empty && !ser_active) : (fifo_level <= thresh);
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk #(
   parameter int FIFO_DEPTH = 8,
   localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          txd,
   input logic          busy,
   input logic          ser_active,
   input logic          en_global,
   input logic          en_tx,
   input logic          cts_fc_en,
   input logic          cts_s,
   input logic          abort_flag,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [LW-1:0] fifo_level
);
   // R1: line rests high whenever nothing is pending or shifting
   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R2: a start edge out of idle needs both enables one cycle earlier
   a_r2_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(txd) && !$past(ser_active)) |-> $past(en_global && en_tx));

   // R3: with gating on, a start edge needs the synchronized clear-to-send
   a_r3_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(txd) && !$past(ser_active) && $past(cts_fc_en)) |-> $past(cts_s));

   // R8: no frame starts while an abort is latched
   a_r8_abort_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(txd) && !$past(ser_active)) |-> !$past(abort_flag));

   // R10: a write into a full queue never raises the fill level
   a_r10_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (fifo_level <= $past(fifo_level)));
endmodule

bind uart_tx_fc uart_tx_fc_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .busy(busy), .ser_active(ser_active),
   .en_global(en_global), .en_tx(en_tx), .cts_fc_en(cts_fc_en), .cts_s(cts_s),
   .abort_flag(abort_flag), .wr_valid(wr_valid), .wr_ready(wr_ready),
   .fifo_level(fifo_level)
);

// File: tb/sim_uart_tx_fc.sv
module sim_uart_tx_fc;
   localparam int DW = 8;
   localparam int DEPTH = 8;
   localparam int LW = $clog2(DEPTH) + 1;
   localparam int TDIV = 4;

   logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
   logic en_global = 1'b1, en_tx = 1'b1, cts_fc_en = 1'b0, cts = 1'b0;
   logic high_speed = 1'b0, eot_mode = 1'b0, smart_mode = 1'b0, two_stop = 1'b0;
   logic par_en = 1'b0, par_odd = 1'b0, wr_valid = 1'b0, abort_clr = 1'b0, nack = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [LW-1:0] thresh = '0;
   logic wr_ready, txd, busy, tx_irq, abort_flag, line_in;
   logic [LW-1:0] fifo_level;

   int n_tests = 0, n_fail = 0, chars_seen = 0;
   int cfg_tpb = 16, cfg_nstop = 1;
   bit cfg_par = 0, cfg_odd = 0, done = 0;
   logic [DW-1:0] exp_q[$];

   always #2.5 clk = ~clk;
   assign line_in = txd & ~nack;

   uart_tx_fc #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en_global(en_global),
      .en_tx(en_tx), .cts_fc_en(cts_fc_en), .cts(cts), .high_speed(high_speed),
      .eot_mode(eot_mode), .smart_mode(smart_mode), .two_stop(two_stop),
      .par_en(par_en), .par_odd(par_odd), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .thresh(thresh), .line_in(line_in), .abort_clr(abort_clr),
      .txd(txd), .busy(busy), .tx_irq(tx_irq), .abort_flag(abort_flag),
      .fifo_level(fifo_level)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [DW-1:0] d, input bit expect_it);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      if (expect_it) exp_q.push_back(d);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (40) @(negedge clk);
   endtask

   task automatic wait_start();
      while (txd !== 1'b1) @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
   endtask

   // baud tick source
   initial begin
      forever begin
         repeat (TDIV - 1) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   // monitor: decode frames and compare against the scoreboard queue
   initial begin
      @(posedge rst_n);
      forever begin
         int bp;
         logic [DW-1:0] got, exp;
         logic pb;
         wait_start();
         bp = cfg_tpb * TDIV;
         repeat (bp / 2) @(negedge clk);
         chk(txd == 1'b0, "R1 start bit low", txd, 0);
         for (int i = 0; i < DW; i++) begin
            repeat (bp) @(negedge clk);
            got[i] = txd;
         end
         if (cfg_par) begin
            repeat (bp) @(negedge clk);
            pb = cfg_odd ? ~(^got) : ^got;
            chk(txd == pb, "R5 parity bit", txd, pb);
         end
         for (int s = 0; s < cfg_nstop; s++) begin
            repeat (bp) @(negedge clk);
            chk(txd == 1'b1, "R6 stop bit high", txd, 1);
         end
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected frame", got, -1);
         end else begin
            exp = exp_q.pop_front();
            chk(got == exp, "R1 data LSB first", got, exp);
         end
         chars_seen++;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int c0;
      repeat (5) @(negedge clk);
      // reset state
      chk(txd == 1'b1, "R1 reset txd", txd, 1);
      chk(busy == 1'b0, "R11 reset busy", busy, 0);
      chk(abort_flag == 1'b0, "R8 reset abort", abort_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_ready == 1'b1, "R10 ready after reset", wr_ready, 1);
      chk(tx_irq == 1'b1, "R9 level 0 <= thresh 0", tx_irq, 1);

      // R1/R4: plain 16x frames, one stop
      push(8'hA5, 1); push(8'h3C, 1);
      @(negedge clk);
      chk(busy == 1'b1, "R11 busy while sending", busy, 1);
      drain();
      chk(chars_seen == 2, "R4 16x frames", chars_seen, 2);

      // R4: 8x
      high_speed = 1'b1; cfg_tpb = 8;
      push(8'h5A, 1); push(8'h81, 1);
      drain();
      chk(chars_seen == 4, "R4 8x frames", chars_seen, 4);
      high_speed = 1'b0; cfg_tpb = 16;

      // R5: even and odd parity
      par_en = 1'b1; cfg_par = 1;
      push(8'h07, 1); drain();
      par_odd = 1'b1; cfg_odd = 1;
      push(8'h07, 1); push(8'hF0, 1); drain();
      chk(chars_seen == 7, "R5 parity frames", chars_seen, 7);
      par_en = 1'b0; par_odd = 1'b0; cfg_par = 0; cfg_odd = 0;

      // R6: two stop bits, back to back
      two_stop = 1'b1; cfg_nstop = 2;
      push(8'h00, 1); push(8'hFF, 1); push(8'h00, 1); drain();
      chk(chars_seen == 10, "R6 two stop frames", chars_seen, 10);
      two_stop = 1'b0; cfg_nstop = 1;

      // R7: smart mode ignores high_speed and two_stop
      smart_mode = 1'b1; high_speed = 1'b1; two_stop = 1'b0; par_en = 1'b1;
      cfg_tpb = 16; cfg_nstop = 2; cfg_par = 1;
      push(8'h00, 1); push(8'h6B, 1); drain();
      chk(chars_seen == 12, "R7 smart frames", chars_seen, 12);
      chk(abort_flag == 1'b0, "R8 no abort on clean line", abort_flag, 0);

      // R8: pull line low mid first stop bit
      push(8'h11, 1);
      wait_start();
      repeat (10 * 64 + 16) @(negedge clk);
      nack = 1'b1;
      repeat (32) @(negedge clk);
      nack = 1'b0;
      drain();
      chk(chars_seen == 13, "R8 aborted frame completes", chars_seen, 13);
      chk(abort_flag == 1'b1, "R8 abort latched", abort_flag, 1);
      push(8'h22, 1);
      repeat (15 * 64) @(negedge clk);
      chk(chars_seen == 13, "R8 held while aborted", chars_seen, 13);
      chk(busy == 1'b1 && txd == 1'b1, "R8 pending with line idle", {busy, txd}, 3);
      abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;
      drain();
      chk(chars_seen == 14, "R8 resumes after clear", chars_seen, 14);
      chk(abort_flag == 1'b0, "R8 flag cleared", abort_flag, 0);
      smart_mode = 1'b0; high_speed = 1'b0; par_en = 1'b0;
      cfg_nstop = 1; cfg_par = 0;

      // R3: CTS gating
      cts_fc_en = 1'b1; cts = 1'b0;
      push(8'h9C, 1);
      repeat (2000) @(negedge clk);
      chk(chars_seen == 14, "R3 held without cts", chars_seen, 14);
      chk(txd == 1'b1, "R3 line idle without cts", txd, 1);
      cts = 1'b1;
      drain();
      chk(chars_seen == 15, "R3 sent with cts", chars_seen, 15);
      cts_fc_en = 1'b0; cts = 1'b0;

      // R2: disable mid-frame completes current only
      push(8'hC3, 1); push(8'h3C, 1);
      wait_start();
      repeat (4 * 64) @(negedge clk);
      en_tx = 1'b0;
      repeat (12 * 64) @(negedge clk);
      chk(chars_seen == 16, "R2 current frame completes", chars_seen, 16);
      repeat (1000) @(negedge clk);
      chk(chars_seen == 16 && txd == 1'b1, "R2 no new frame when disabled", chars_seen, 16);
      en_tx = 1'b1;
      drain();
      chk(chars_seen == 17, "R2 resumes on enable", chars_seen, 17);

      // R9: threshold mode
      en_global = 1'b0;
      push(8'h01, 1); push(8'h02, 1); push(8'h03, 1);
      thresh = LW'(2);
      @(negedge clk);
      chk(tx_irq == 1'b0, "R9 level 3 > thresh 2", tx_irq, 0);
      thresh = LW'(3);
      @(negedge clk);
      chk(tx_irq == 1'b1, "R9 level 3 <= thresh 3", tx_irq, 1);
      en_global = 1'b1;
      drain();
      thresh = '0;

      // R9: end-of-transmission mode
      eot_mode = 1'b1;
      push(8'h44, 1);
      wait_start();
      repeat (64) @(negedge clk);
      chk(tx_irq == 1'b0, "R9 eot low while shifting", tx_irq, 0);
      drain();
      chk(tx_irq == 1'b1, "R9 eot high when empty", tx_irq, 1);
      eot_mode = 1'b0;

      // R10: full queue drops extra write, order kept
      en_tx = 1'b0;
      c0 = chars_seen;
      for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i), 1);
      chk(wr_ready == 1'b0, "R10 not ready when full", wr_ready, 0);
      chk(fifo_level == LW'(DEPTH), "R10 level full", fifo_level, DEPTH);
      push(8'hEE, 0);
      en_tx = 1'b1;
      drain();
      chk(chars_seen == c0 + DEPTH, "R10 extra write dropped", chars_seen - c0, DEPTH);
      chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
      chk(busy == 1'b0 && txd == 1'b1, "R11 idle at end", {busy, txd}, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule